// File: doc/BRIEF.md
# Power-Up Register Initialization Sequencer

This block configures other blocks of the chip, for example an Ethernet MAC, before user logic starts. It holds a compile-time table of address/data pairs. After reset is released it works through the table and issues one APB write per entry, with no software involved. It waits for each transfer to complete before it starts the next.

Each table entry is a packed 64-bit word. The upper half is the target address and the lower half is the write data. When the last write completes, a sticky completion flag rises in the APB clock domain. Downstream logic can hold itself off until that flag is seen.

A slave may stretch any transfer with wait states or answer with an error response. An error response sets a second sticky flag, and the sequence carries on with the next entry.

Top module: `cfg_boot_writer`

## Requirements
- R1: While `rst` is high, `apb_psel`, `apb_penable`, `boot_done` and `boot_fault` are all 0.
- R2: Entry k of `BOOT_TABLE` occupies bits [64k+63:64k]. Within an entry, bits [63:32] are the address and bits [31:0] are the write data; for example, an entry of {0x1000_0020, 0x0000_00FF} writes 0x0000_00FF to address 0x1000_0020. Entries are written exactly once each, in ascending index order from 0 to NUM_ENTRIES-1.
- R3: Every transfer starts with exactly one setup cycle (`apb_psel`=1, `apb_penable`=0), which is followed by access cycles (`apb_psel`=1, `apb_penable`=1).
- R4: During access cycles the address and data are held stable until the slave raises `apb_pready`. `apb_pslverr` is ignored in any cycle where `apb_pready` is 0.
- R5: Every transfer has `apb_pwrite`=1 and `apb_pstrb`=4'b1111.
- R6: `boot_done` rises in the cycle after the access cycle in which the last entry completes. It stays high until the next reset, and no APB transfer is issued while it is high.
- R7: A completed transfer with `apb_pslverr`=1 sets `boot_fault`. The flag stays set until reset, and the remaining entries are still written.
- R8: With NUM_ENTRIES = 0, `boot_done` is 1 one cycle after reset is released, and `apb_psel` never rises.
- R9: With NUM_ENTRIES > 0, the first setup cycle is in the first cycle after reset is released.
- R10: A reset in the middle of the sequence clears both flags, and the sequence then restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous active-high reset |
| apb_psel | output | 1 | APB select |
| apb_penable | output | 1 | APB enable (access phase) |
| apb_pwrite | output | 1 | APB write direction, always 1 |
| apb_paddr | output | 32 | APB address from the current entry |
| apb_pwdata | output | 32 | APB write data from the current entry |
| apb_pstrb | output | 4 | APB byte strobes, always all ones |
| apb_pready | input | 1 | Slave completes the access phase |
| apb_pslverr | input | 1 | Slave error response, sampled with pready |
| boot_done | output | 1 | Sticky: all entries written |
| boot_fault | output | 1 | Sticky: at least one entry got an error response |

## Verification
The hardest case to reach from the ports is a reset that lands part-way through the table while a fault is already latched. The bench waits for the slave model to count three completed transfers, with an error injected on entry 1, and then applies reset. It confirms that both flags clear and that the following transfers begin again at entry 0. Wait-state lengths and error positions are drawn at random from a fixed seed, and the slave drives `apb_pslverr` with noise whenever `apb_pready` is low. This shows that only completing cycles can set the fault flag. An error on the final entry checks that the fault and the completion flag appear together.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ENTRY_W = ADDR_W + DATA_W;
    localparam int unsigned STRB_W  = DATA_W / 8;

    // One table word: address in the upper half, data in the lower half
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } boot_entry_t;

    typedef enum logic [1:0] {
        ST_START    = 2'd0,
        ST_SETUP    = 2'd1,
        ST_ACCESS   = 2'd2,
        ST_FINISHED = 2'd3
    } boot_state_t;

    function automatic logic xfer_complete(boot_state_t st, logic rdy);
        return (st == ST_ACCESS) && rdy;
    endfunction

    function automatic int unsigned table_depth(int unsigned n);
        return (n > 0) ? n : 1;
    endfunction

endpackage

// File: rtl/cfg_boot_cursor.sv
module cfg_boot_cursor
    import cfg_boot_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    localparam int unsigned DEPTH = table_depth(NUM_ENTRIES),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    assign at_last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step && !at_last) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_boot_apb_fsm.sv
module cfg_boot_apb_fsm
    import cfg_boot_pkg::*;
#(
    parameter bit EMPTY_TABLE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pready,
    input  logic        at_last,
    output boot_state_t state,
    output logic        ack,
    output logic        step,
    output logic        finish
);

    boot_state_t state_nxt;

    assign ack    = xfer_complete(state, pready);
    assign step   = ack && !at_last;
    assign finish = ((state == ST_START) && EMPTY_TABLE) || (ack && at_last);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_START:    state_nxt = EMPTY_TABLE ? ST_FINISHED : ST_SETUP;
            ST_SETUP:    state_nxt = ST_ACCESS;
            ST_ACCESS:   if (pready) state_nxt = at_last ? ST_FINISHED : ST_SETUP;
            ST_FINISHED: state_nxt = ST_FINISHED;
            default:     state_nxt = ST_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_START;
        else     state <= state_nxt;
    end

endmodule

// File: rtl/cfg_boot_flags.sv
module cfg_boot_flags (
    input  logic clk,
    input  logic rst,
    input  logic finish,
    input  logic ack,
    input  logic slverr,
    output logic done_q,
    output logic fault_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (finish)         done_q  <= 1'b1;
            if (ack && slverr)  fault_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_boot_writer.sv
module cfg_boot_writer
    import cfg_boot_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    parameter logic [table_depth(NUM_ENTRIES)*ENTRY_W-1:0] BOOT_TABLE = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              apb_psel,
    output logic              apb_penable,
    output logic              apb_pwrite,
    output logic [ADDR_W-1:0] apb_paddr,
    output logic [DATA_W-1:0] apb_pwdata,
    output logic [STRB_W-1:0] apb_pstrb,
    input  logic              apb_pready,
    input  logic              apb_pslverr,
    output logic              boot_done,
    output logic              boot_fault
);

    localparam int unsigned DEPTH = table_depth(NUM_ENTRIES);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    boot_entry_t      entries [DEPTH];
    boot_entry_t      cur;
    logic [IDX_W-1:0] idx;
    logic             at_last;
    boot_state_t      state;
    logic             ack;
    logic             step;
    logic             finish;

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        assign entries[k] = boot_entry_t'(BOOT_TABLE[k*ENTRY_W +: ENTRY_W]);
    end

    cfg_boot_cursor #(
        .NUM_ENTRIES(NUM_ENTRIES)
    ) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .idx     (idx),
        .at_last (at_last)
    );

    cfg_boot_apb_fsm #(
        .EMPTY_TABLE(NUM_ENTRIES == 0)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pready  (apb_pready),
        .at_last (at_last),
        .state   (state),
        .ack     (ack),
        .step    (step),
        .finish  (finish)
    );

    cfg_boot_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .finish  (finish),
        .ack     (ack),
        .slverr  (apb_pslverr),
        .done_q  (boot_done),
        .fault_q (boot_fault)
    );

    assign cur         = entries[idx];
    assign apb_psel    = (state == ST_SETUP) || (state == ST_ACCESS);
    assign apb_penable = (state == ST_ACCESS);
    assign apb_pwrite  = 1'b1;
    assign apb_pstrb   = '1;
    assign apb_paddr   = cur.addr;
    assign apb_pwdata  = cur.data;

endmodule

// File: rtl/cfg_boot_writer_chk.sv
module cfg_boot_writer_chk
    import cfg_boot_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              apb_psel,
    input logic              apb_penable,
    input logic              apb_pwrite,
    input logic [ADDR_W-1:0] apb_paddr,
    input logic [DATA_W-1:0] apb_pwdata,
    input logic [STRB_W-1:0] apb_pstrb,
    input logic              apb_pready,
    input logic              apb_pslverr,
    input logic              boot_done,
    input logic              boot_fault
);

    // R3: setup is followed by access
    p_setup_to_access_r3: assert property (@(posedge clk) disable iff (rst)
        (apb_psel && !apb_penable) |=> (apb_psel && apb_penable));

    // R3: enable never without select
    p_enable_needs_sel_r3: assert property (@(posedge clk) disable iff (rst)
        apb_penable |-> apb_psel);

    // R4: wait states hold the transfer
    p_hold_in_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (apb_psel && apb_penable && !apb_pready) |=>
        (apb_psel && apb_penable && $stable(apb_paddr) && $stable(apb_pwdata)));

    // R5: write with full strobes
    p_write_strobes_r5: assert property (@(posedge clk) disable iff (rst)
        apb_psel |-> (apb_pwrite && (apb_pstrb == {STRB_W{1'b1}})));

    // R6: completion is sticky
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> boot_done);

    // R6: bus quiet once done
    p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> !apb_psel);

    // R7: fault is sticky
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        boot_fault |=> boot_fault);

    // R7: fault only from a completing error response
    p_fault_source_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_fault) |->
        $past(apb_psel && apb_penable && apb_pready && apb_pslverr));

endmodule

bind cfg_boot_writer cfg_boot_writer_chk u_chk (.*);

// File: tb/cfg_boot_writer_tb.sv
`timescale 1ns/1ps
module cfg_boot_writer_tb;

    localparam int unsigned N = 6;

    function automatic logic [63:0] exp_entry(int k);
        if (k == 0) return {32'h1000_0020, 32'h0000_00FF};
        return {32'h2000_0000 + 32'(k * 8), 32'hC0DE_0000 + 32'(k * 3)};
    endfunction

    function automatic logic [N*64-1:0] build_tbl();
        logic [N*64-1:0] t;
        t = '0;
        for (int k = 0; k < N; k++) t[k*64 +: 64] = exp_entry(k);
        return t;
    endfunction

    localparam logic [N*64-1:0] TBL = build_tbl();

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        psel, penable, pwrite, pready, pslverr, done, fault;
    logic [31:0] paddr, pwdata;
    logic [3:0]  pstrb;
    logic        e_psel, e_penable, e_pwrite, e_done, e_fault;
    logic [31:0] e_paddr, e_pwdata;
    logic [3:0]  e_pstrb;

    cfg_boot_writer #(.NUM_ENTRIES(N), .BOOT_TABLE(TBL)) u_dut (
        .clk(clk), .rst(rst),
        .apb_psel(psel), .apb_penable(penable), .apb_pwrite(pwrite),
        .apb_paddr(paddr), .apb_pwdata(pwdata), .apb_pstrb(pstrb),
        .apb_pready(pready), .apb_pslverr(pslverr),
        .boot_done(done), .boot_fault(fault));

    cfg_boot_writer #(.NUM_ENTRIES(0)) u_dut_empty (
        .clk(clk), .rst(rst),
        .apb_psel(e_psel), .apb_penable(e_penable), .apb_pwrite(e_pwrite),
        .apb_paddr(e_paddr), .apb_pwdata(e_pwdata), .apb_pstrb(e_pstrb),
        .apb_pready(1'b0), .apb_pslverr(1'b0),
        .boot_done(e_done), .boot_fault(e_fault));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // slave model and monitor
    logic [N-1:0] err_mask = '0;
    int           max_wait = 0;
    int           wait_left = 0;
    int           xfer_idx = 0;
    bit           pend_last = 0;
    bit           prev_setup = 0;
    bit           bad_after_done = 0;
    bit           e_sel_seen = 0;
    logic [31:0]  setup_addr;

    always @(negedge clk) begin
        if (e_psel) e_sel_seen = 1;
        if (rst) begin
            pready = 0; pslverr = 0; wait_left = 0; xfer_idx = 0;
            pend_last = 0; prev_setup = 0; bad_after_done = 0;
        end else begin
            if (pend_last) begin
                chk(done === 1'b1, "R6 done after last", 64'(done), 64'd1);
                chk(fault === (|err_mask), "R7 fault at end", 64'(fault), 64'(|err_mask));
                pend_last = 0;
            end
            if (done && psel) bad_after_done = 1;
            if (prev_setup)
                chk(psel && penable, "R3 access follows setup", {62'd0, psel, penable}, 64'd3);
            prev_setup = 0;
            pready = 0;
            pslverr = 1'($urandom % 2);
            if (psel && !penable) begin
                prev_setup = 1;
                setup_addr = paddr;
                wait_left = (max_wait > 0) ? int'($urandom % (max_wait + 1)) : 0;
            end else if (psel && penable) begin
                chk(paddr === setup_addr, "R4 address held", 64'(paddr), 64'(setup_addr));
                if (wait_left == 0) begin
                    pready = 1;
                    if (xfer_idx < N) begin
                        pslverr = err_mask[xfer_idx];
                        chk({paddr, pwdata} === exp_entry(xfer_idx), "R2 entry order/content",
                            {paddr, pwdata}, exp_entry(xfer_idx));
                        chk(pwrite && pstrb == 4'hF, "R5 write strobes",
                            {59'd0, pwrite, pstrb}, {59'd0, 1'b1, 4'hF});
                        chk(done === 1'b0, "R6 done not early", 64'(done), 64'd0);
                        if (xfer_idx == N - 1) pend_last = 1;
                    end else begin
                        chk(0, "R2 extra transfer", 64'(xfer_idx), 64'(N));
                    end
                    xfer_idx++;
                end else begin
                    wait_left--;
                end
            end
        end
    end

    task automatic hold_reset(int cycles);
        @(negedge clk);
        rst = 1;
        repeat (cycles) @(negedge clk);
        chk(!psel && !penable && !done && !fault, "R1 reset state",
            {60'd0, psel, penable, done, fault}, 64'd0);
    endtask

    task automatic release_and_run(logic [N-1:0] mask, int mw, bit first_check);
        int guard;
        err_mask = mask;
        max_wait = mw;
        rst = 0;
        @(negedge clk);
        if (first_check)
            chk(psel && !penable, "R9 first setup", {62'd0, psel, penable}, 64'd2);
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(done === 1'b1, "R6 sequence completes", 64'(done), 64'd1);
        repeat (5) @(negedge clk);
        chk(xfer_idx == N, "R2 transfer count", 64'(xfer_idx), 64'(N));
        chk(!bad_after_done && done, "R6 sticky and quiet", {62'd0, bad_after_done, done}, 64'd1);
        chk(fault === (|mask), "R7 fault sticky", 64'(fault), 64'(|mask));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hold_reset(3);
        // R8: empty table
        chk(e_done === 1'b0, "R8 empty done low in reset", 64'(e_done), 64'd0);
        rst = 0;
        @(negedge clk);
        chk(e_done === 1'b1, "R8 empty done after one cycle", 64'(e_done), 64'd1);
        chk(psel && !penable, "R9 first setup", {62'd0, psel, penable}, 64'd2);
        // finish the first directed run: no waits, no errors
        err_mask = '0; max_wait = 0;
        begin
            int guard = 0;
            while (!done && guard < 5000) begin @(negedge clk); guard++; end
        end
        repeat (3) @(negedge clk);
        chk(xfer_idx == N && !fault, "R2 zero-wait run", 64'(xfer_idx), 64'(N));
        chk(!e_sel_seen && e_done, "R8 empty never selects", {62'd0, e_sel_seen, e_done}, 64'd1);

        // directed: error on entry 2, waits
        hold_reset(2);
        release_and_run(6'b000100, 3, 1);
        // directed: error on the last entry only
        hold_reset(2);
        release_and_run(6'b100000, 2, 1);
        // directed: every entry errors
        hold_reset(2);
        release_and_run(6'b111111, 1, 0);
        // random runs
        for (int r = 0; r < 6; r++) begin
            hold_reset(2);
            release_and_run(N'($urandom), int'($urandom % 6), 1);
        end
        // R10: reset in mid-sequence with a latched fault
        hold_reset(2);
        err_mask = 6'b000010; max_wait = 2;
        rst = 0;
        begin
            int guard = 0;
            while (xfer_idx < 3 && guard < 5000) begin @(negedge clk); guard++; end
        end
        chk(fault === 1'b1, "R7 fault set mid-run", 64'(fault), 64'd1);
        chk(done === 1'b0, "R10 not done mid-run", 64'(done), 64'd0);
        hold_reset(2);
        chk(xfer_idx == 0, "R10 restart index", 64'(xfer_idx), 64'd0);
        release_and_run(6'b000000, 4, 1);

        chk(!e_sel_seen, "R8 empty never selects", 64'(e_sel_seen), 64'd0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule